// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a small serial EEPROM over a three-wire synchronous link: a select line, a serial clock and a command line towards the memory, plus one return line from it. A host presents a 4-bit word address together with a one-cycle start request. The block then raises select, shifts out a fixed 10-bit read command that ends in the address, and clocks in sixteen data bits. It then lowers select and hands the word back together with a one-cycle completion pulse.

All link timing is built from one parameter, the number of system clock cycles in one microsecond. Each bit slot has three parts: a 1 µs setup interval with the clock low, a 2 µs high phase and a 2 µs low phase. A 1 µs guard interval comes before the first clock edge, and another follows the release of select.

Top module: `mw_eeprom_reader`

## Requirements
- R1: The outgoing command is the 10-bit value 0x180 with the word address in bits 3..0, presented on `ee_mosi` most significant bit first. The memory takes one bit on each of the first ten rising edges of `ee_clk`.
- R2: After `ee_sel` rises, the first rising edge of `ee_clk` comes exactly 2·CYC_PER_US cycles later. This is a 1 µs select setup interval plus a 1 µs data setup interval.
- R3: `ee_mosi` never changes while `ee_clk` is high. Each rising edge of `ee_clk` comes at least CYC_PER_US cycles after the last change of `ee_mosi`.
- R4: Every high phase of `ee_clk` lasts exactly 2·CYC_PER_US cycles. Every gap from a falling edge to the next rising edge within a transaction lasts exactly 3·CYC_PER_US cycles, which is a 2 µs low phase followed by 1 µs of setup.
- R5: One transaction gives exactly 26 rising edges of `ee_clk`: 10 for the command and 16 for the read. `ee_mosi` is low on each of the 16 read edges.
- R6: The memory changes `ee_miso` after each read rising edge. The block samples `ee_miso` at the end of each of the 16 read high phases and assembles the word most significant bit first.
- R7: `ee_sel` falls only after the low phase of the last read clock. `done` rises exactly CYC_PER_US cycles after `ee_sel` falls.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle that `done` is high. A start while `busy` is high is ignored: the running read keeps its address and its timing.
- R9: `done` is high for exactly one cycle. `rdata` changes only together with `done` and otherwise holds the last word read.
- R10: After a synchronous reset `ee_sel`, `ee_clk`, `ee_mosi`, `busy` and `done` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle read request, accepted when idle |
| addr | input | 4 | Word address captured with an accepted start |
| ee_sel | output | 1 | Memory select |
| ee_clk | output | 1 | Serial clock to the memory |
| ee_mosi | output | 1 | Command bits to the memory |
| ee_miso | input | 1 | Data bits from the memory |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read |

## Verification
A wrong phase timer or state shows at the link pins within one bit slot, because each phase length of `ee_clk` is measured against its exact cycle count. A wrong bit counter shows when `ee_sel` falls, since the count of rising clock edges or the captured command is then off. A fault in the command or capture shift path shows up only once the transaction ends: either the frame the memory model received is wrong, or `rdata` differs from the stored word. Ignored starts and the holding of `rdata` are checked at the ports through the address that was actually sent and the word that was returned.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int ADDR_W = 4;
    localparam int CMD_W  = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_SETUP,
        ST_BIT_SETUP,
        ST_CLK_HIGH,
        ST_CLK_LOW,
        ST_SEL_HOLD
    } mw_state_e;

    typedef struct packed {
        logic sel;
        logic sck;
        logic mosi;
    } mw_pins_t;

    // read opcode: start bit 1 after a leading zero, then 2'b10, then padding
    function automatic logic [CMD_W-1:0] make_read_frame(input logic [ADDR_W-1:0] a);
        return {3'b011, 3'b000, a};
    endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !expired); // R4

endmodule

// File: rtl/mw_frame_unit.sv
module mw_frame_unit
    import mw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic              capture,
    input  logic              ser_in,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_word
);
    logic [CMD_W-1:0]  frame;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
            shreg <= '0;
        end else begin
            if (load)
                frame <= make_read_frame(addr);
            if (capture)
                shreg <= {shreg[DATA_W-2:0], ser_in};
        end
    end

    always_comb begin
        tx_bit = 1'b0;
        if (idx < IDX_W'(CMD_W))
            tx_bit = frame[CMD_W-1-int'(idx)];
    end

    assign rx_word = shreg;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        capture |=> (shreg[0] == $past(ser_in))); // R6

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mw_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        addr,
    output logic              ee_sel,
    output logic              ee_clk,
    output logic              ee_mosi,
    input  logic              ee_miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int TOTAL_BITS = CMD_W + DATA_W;
    localparam int IDX_W      = $clog2(TOTAL_BITS + 1);
    localparam int TMR_W      = $clog2(2 * CYC_PER_US + 1);
    localparam logic [TMR_W-1:0] T_ONE = TMR_W'(CYC_PER_US - 1);
    localparam logic [TMR_W-1:0] T_TWO = TMR_W'(2 * CYC_PER_US - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);

    mw_state_e         state;
    mw_pins_t          pins;
    logic [IDX_W-1:0]  bitcnt;
    logic [IDX_W-1:0]  nxt_idx;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              frm_load;
    logic              capture;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_word;
    logic              in_read;

    assign in_read = (bitcnt >= IDX_W'(CMD_W));
    assign nxt_idx = (state == ST_SEL_SETUP) ? '0 : bitcnt + 1'b1;
    assign frm_load = (state == ST_IDLE) && start;
    assign capture  = (state == ST_CLK_HIGH) && tmr_done && in_read;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = T_ONE;
        case (state)
            ST_IDLE:      tmr_load = start;
            ST_SEL_SETUP: tmr_load = tmr_done;
            ST_BIT_SETUP: begin tmr_load = tmr_done; tmr_val = T_TWO; end
            ST_CLK_HIGH:  begin tmr_load = tmr_done; tmr_val = T_TWO; end
            ST_CLK_LOW:   tmr_load = tmr_done;
            default:      tmr_load = 1'b0;
        endcase
    end

    mw_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    mw_frame_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .load    (frm_load),
        .addr    (addr),
        .idx     (nxt_idx),
        .capture (capture),
        .ser_in  (ee_miso),
        .tx_bit  (tx_bit),
        .rx_word (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pins   <= '0;
            bitcnt <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pins.sel <= 1'b1;
                        busy     <= 1'b1;
                        bitcnt   <= '0;
                        state    <= ST_SEL_SETUP;
                    end
                end
                ST_SEL_SETUP: begin
                    if (tmr_done) begin
                        pins.mosi <= tx_bit;
                        bitcnt    <= '0;
                        state     <= ST_BIT_SETUP;
                    end
                end
                ST_BIT_SETUP: begin
                    if (tmr_done) begin
                        pins.sck <= 1'b1;
                        state    <= ST_CLK_HIGH;
                    end
                end
                ST_CLK_HIGH: begin
                    if (tmr_done) begin
                        pins.sck <= 1'b0;
                        state    <= ST_CLK_LOW;
                    end
                end
                ST_CLK_LOW: begin
                    if (tmr_done) begin
                        if (bitcnt == LAST_IDX) begin
                            pins.sel  <= 1'b0;
                            pins.mosi <= 1'b0;
                            state     <= ST_SEL_HOLD;
                        end else begin
                            bitcnt    <= nxt_idx;
                            pins.mosi <= tx_bit;
                            state     <= ST_BIT_SETUP;
                        end
                    end
                end
                ST_SEL_HOLD: begin
                    if (tmr_done) begin
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        rdata <= rx_word;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ee_sel  = pins.sel;
    assign ee_clk  = pins.sck;
    assign ee_mosi = pins.mosi;

    AST_CLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        ee_clk |-> ee_sel); // R7
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ee_clk && $past(ee_clk)) |-> $stable(ee_mosi)); // R3
    AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_clk) |-> $stable(ee_mosi)); // R3
    AST_MOSI_LOW_READ: assert property (@(posedge clk) disable iff (rst)
        (ee_clk && in_read) |-> !ee_mosi); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rdata)); // R9
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R8
    AST_DONE_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ee_sel && !busy)); // R7

endmodule

// File: tb/mw_eeprom_reader_test.sv
`timescale 1ns/1ps
module mw_eeprom_reader_test;

    localparam int C = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  addr = '0;
    logic        ee_sel, ee_clk, ee_mosi, busy, done;
    logic        ee_miso = 1'b0;
    logic [15:0] rdata;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mw_eeprom_reader #(.CYC_PER_US(C), .DATA_W(16)) uut (
        .clk(clk), .rst(rst), .start(start), .addr(addr),
        .ee_sel(ee_sel), .ee_clk(ee_clk), .ee_mosi(ee_mosi),
        .ee_miso(ee_miso), .busy(busy), .done(done), .rdata(rdata)
    );

    logic [15:0] mem [16];
    logic [3:0]  exp_addr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // link monitor and memory model, sampled on the falling clock edge
    int       cyc = 0;
    int       t_sel, t_rise, t_fall, t_mosi, t_self;
    int       nrise;
    logic [9:0] cap;
    logic     p_sel = 0, p_clk = 0, p_mosi = 0, mon_on = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (ee_sel && !p_sel) begin
                t_sel = cyc; nrise = 0; cap = '0;
            end
            if (ee_mosi !== p_mosi) begin
                tests++;
                if (ee_clk && p_clk) begin
                    fails++; $display("FAIL R3: mosi moved in high phase, actual 1 expected 0");
                end
                t_mosi = cyc;
            end
            if (ee_clk && !p_clk) begin
                if (nrise == 0) chk("R2", cyc - t_sel, 2 * C);
                else            chk("R4", cyc - t_fall, 3 * C);
                tests++;
                if (cyc - t_mosi < C) begin
                    fails++; $display("FAIL R3: setup actual %0d expected >= %0d", cyc - t_mosi, C);
                end
                nrise++;
                t_rise = cyc;
                if (nrise <= 10) cap = {cap[8:0], ee_mosi};
                else begin
                    chk("R5", ee_mosi, 0);
                    ee_miso = mem[cap[3:0]][26 - nrise];
                end
            end
            if (!ee_clk && p_clk) begin
                chk("R4", cyc - t_rise, 2 * C);
                t_fall = cyc;
            end
            if (!ee_sel && p_sel) begin
                t_self = cyc;
                chk("R5", nrise, 26);
                chk("R1", cap, 10'h180 | exp_addr);
                chk("R7", ee_clk, 0);
            end
            if (done) chk("R7", cyc - t_self, C);
        end
        p_sel = ee_sel; p_clk = ee_clk; p_mosi = ee_mosi;
    end

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
        if (!ok) begin
            tests++; fails++;
            $display("FAIL R8: done timeout, actual 0 expected 1");
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 sel", ee_sel, 0);
        chk("R10 clk", ee_clk, 0);
        chk("R10 mosi", ee_mosi, 0);
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 rdata", rdata, 0);
        rst = 1'b0;
        mon_on = 1;
    endtask

    task automatic t_read(input logic [3:0] a);
        bit ok;
        exp_addr = a;
        @(negedge clk); start = 1; addr = a;
        @(negedge clk); start = 0; addr = ~a;
        chk("R8 busy rise", busy, 1);
        wait_done(ok);
        if (ok) begin
            chk("R6 word", rdata, mem[a]);
            chk("R8 busy fall", busy, 0);
            @(negedge clk);
            chk("R9 pulse", done, 0);
        end
    endtask

    task automatic t_ignore_start;
        bit ok;
        exp_addr = 4'h3;
        @(negedge clk); start = 1; addr = 4'h3;
        @(negedge clk); start = 0;
        repeat (400) @(negedge clk);
        start = 1; addr = 4'hC;
        @(negedge clk); start = 0;
        wait_done(ok);
        if (ok) chk("R8 ignored start", rdata, mem[4'h3]);
        repeat (4 * C) @(negedge clk);
        chk("R8 no restart", ee_sel, 0);
        chk("R8 idle", busy, 0);
    endtask

    task automatic t_hold;
        logic [15:0] keep;
        keep = rdata;
        repeat (50) @(negedge clk);
        chk("R9 hold", rdata, keep);
        chk("R9 done low", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'(16'h1357 * (i + 1)) ^ 16'hC3A5;
        mem[0] = 16'hFFFF; mem[15] = 16'h0000; mem[5] = 16'hA5A5; mem[10] = 16'h8001;
        exp_addr = '0;
        t_reset();
        t_read(4'h0);
        t_read(4'hF);
        t_read(4'h5);
        t_read(4'hA);
        t_hold();
        t_ignore_start();
        t_read(4'h7);
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        tests++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule